// File: doc/BRIEF.md
# Registered Adder Tester

This block runs an unattended check of an adder whose two operands and its sum each pass through a register. A small set of constant operand pairs is built into the block. A case index walks through them at a slow pace, so a person can read the result on LEDs. Each pair is applied to the adder. The sum that comes out is compared with a precomputed expected sum, and a registered mismatch flag reports the result of that comparison. The expected sum travels through its own two delay registers, so it meets the sum computed from the same operands.

The pace comes from a free-running counter. A one-cycle step pulse is produced each time the counter's top bit falls. Every register stays on the one main clock, and the step pulse acts only as an enable. A small three-state controller tracks how full the pipeline is after each step: fill operands (`ST_FILL_OPS`), fill sum (`ST_FILL_SUM`) and comparing (`ST_COMPARE`). A fault input corrupts the adder's sum so that the flag can be shown to work. The block's outputs are the registered operands, the registered sum and the flag.

Top module: `adt_tester`

## Requirements
- R1: The operand outputs show the table entry for the current case one clock after the index selects it. Case i has operand A = (73*i + 255) mod 256 and operand B = (29*i + 3) mod 256.
- R2: The sum output is the 8-bit truncated sum of the registered operands. It appears one clock after those operands, so it lags the case index by two clocks.
- R3: The case index starts at 0 and advances by one on each step pulse. After the last case (NUM_CASES-1, default 5) it wraps to 0.
- R4: The step pulse lasts one cycle and fires when the top bit of a STEP_CNT_W-bit free-running counter falls. After reset, case 0 is held for 2^STEP_CNT_W + 1 clocks. Every later case is held for 2^STEP_CNT_W clocks.
- R5: The controller has three transitions. Reset and every step enter `ST_FILL_OPS`. `ST_FILL_OPS` moves to `ST_FILL_SUM`. `ST_FILL_SUM` moves to `ST_COMPARE`, which stays in place until the next step. The mismatch flag updates only in `ST_COMPARE` and holds its value through the two fill cycles.
- R6: In `ST_COMPARE`, the flag is set to 1 when the registered sum differs from the twice-delayed expected sum, and it is cleared to 0 when they match.
- R7: While `fault_inj` is 1, bit 0 of the value entering the sum register is inverted.
- R8: An asynchronous active-high reset immediately clears the counter, the index, the operand, sum and expected registers and the flag to 0. After release, the sequence restarts from case 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst | input | 1 | Asynchronous active-high reset |
| fault_inj | input | 1 | Inverts bit 0 of the adder's next sum |
| shown_a | output | 8 | Registered operand A |
| shown_b | output | 8 | Registered operand B |
| shown_sum | output | 8 | Registered sum |
| mismatch | output | 1 | Registered comparison result |

## Verification
A clean sweep runs through every case twice with no fault. It confirms the operand values, the two-clock sum latency, the longer first case and the index wrap, and it shows the flag stays low when the expected sum is aligned correctly. A one-clock fault inside a compare window shows the flag rising and then clearing, with the correct lag. A fault held until just before an index change, and a fault present from reset, separate a flag that is gated during the fill cycles from one that compares every cycle. A reset in the middle of a run shows the asynchronous clear and the restart from case 0.

// File: rtl/adt_pkg.sv
package adt_pkg;

    localparam int DATA_W = 8;

    typedef enum logic [1:0] {
        ST_FILL_OPS,
        ST_FILL_SUM,
        ST_COMPARE
    } chk_state_t;

    function automatic logic [DATA_W-1:0] case_op_a(input int unsigned i);
        return DATA_W'(i * 73 + 255);
    endfunction

    function automatic logic [DATA_W-1:0] case_op_b(input int unsigned i);
        return DATA_W'(i * 29 + 3);
    endfunction

    function automatic logic [DATA_W-1:0] case_expect(input int unsigned i);
        return case_op_a(i) + case_op_b(i);
    endfunction

endpackage

// File: rtl/adt_step_gen.sv
module adt_step_gen #(
    parameter int CNT_W = 27
) (
    input  logic clk,
    input  logic rst,
    output logic step
);

    localparam int TOP = CNT_W - 1;

    logic [CNT_W-1:0] cnt;
    logic             tap_d;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            cnt   <= '0;
            tap_d <= 1'b0;
        end else begin
            cnt   <= cnt + 1'b1;
            tap_d <= cnt[TOP];
        end
    end

    // falling edge of the tapped bit
    assign step = tap_d & ~cnt[TOP];

    // R4: one-cycle pulse
    p_step_single_r4: assert property (@(posedge clk) disable iff (rst)
        step |=> !step);

endmodule

// File: rtl/adt_sequencer.sv
module adt_sequencer
    import adt_pkg::*;
#(
    parameter int NUM_CASES = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step,
    output logic [DATA_W-1:0] tab_a,
    output logic [DATA_W-1:0] tab_b,
    output logic [DATA_W-1:0] tab_exp,
    output logic              cmp_en
);

    localparam int               IDX_W = (NUM_CASES > 1) ? $clog2(NUM_CASES) : 1;
    localparam logic [IDX_W-1:0] LAST  = IDX_W'(NUM_CASES - 1);

    logic [DATA_W-1:0] rom_a   [NUM_CASES];
    logic [DATA_W-1:0] rom_b   [NUM_CASES];
    logic [DATA_W-1:0] rom_exp [NUM_CASES];

    for (genvar g = 0; g < NUM_CASES; g++) begin : g_case
        assign rom_a[g]   = case_op_a(g);
        assign rom_b[g]   = case_op_b(g);
        assign rom_exp[g] = case_expect(g);
    end

    logic [IDX_W-1:0] idx;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            idx <= '0;
        end else if (step) begin
            idx <= (idx == LAST) ? '0 : idx + 1'b1;
        end
    end

    assign tab_a   = rom_a[idx];
    assign tab_b   = rom_b[idx];
    assign tab_exp = rom_exp[idx];

    chk_state_t state, state_nxt;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) state <= ST_FILL_OPS;
        else     state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_FILL_OPS: state_nxt = ST_FILL_SUM;
            ST_FILL_SUM: state_nxt = ST_COMPARE;
            ST_COMPARE:  state_nxt = ST_COMPARE;
            default:     state_nxt = ST_FILL_OPS;
        endcase
        if (step) state_nxt = ST_FILL_OPS;
    end

    always_comb begin
        unique case (state)
            ST_COMPARE: cmp_en = 1'b1;
            default:    cmp_en = 1'b0;
        endcase
    end

    p_idx_range_r3: assert property (@(posedge clk) disable iff (rst)
        idx <= LAST);

    p_idx_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(idx));

    p_idx_wrap_r3: assert property (@(posedge clk) disable iff (rst)
        (step && idx == LAST) |=> idx == '0);

endmodule

// File: rtl/adt_reg_adder.sv
module adt_reg_adder
    import adt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] op_a_d,
    input  logic [DATA_W-1:0] op_b_d,
    input  logic              flip_lsb,
    output logic [DATA_W-1:0] a_q,
    output logic [DATA_W-1:0] b_q,
    output logic [DATA_W-1:0] s_q
);

    logic [DATA_W-1:0] s_d;

    assign s_d = (a_q + b_q) ^ {{(DATA_W-1){1'b0}}, flip_lsb};

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            a_q <= '0;
            b_q <= '0;
            s_q <= '0;
        end else begin
            a_q <= op_a_d;
            b_q <= op_b_d;
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/adt_result_check.sv
module adt_result_check
    import adt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] exp_in,
    input  logic [DATA_W-1:0] sum_in,
    input  logic              cmp_en,
    output logic              err
);

    logic [DATA_W-1:0] exp_s1, exp_s2;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            exp_s1 <= '0;
            exp_s2 <= '0;
            err    <= 1'b0;
        end else begin
            exp_s1 <= exp_in;
            exp_s2 <= exp_s1;
            if (cmp_en) err <= (sum_in != exp_s2);
        end
    end

    p_err_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !cmp_en |=> $stable(err));

    p_err_clear_r6: assert property (@(posedge clk) disable iff (rst)
        (cmp_en && sum_in == exp_s2) |=> !err);

endmodule

// File: rtl/adt_tester.sv
module adt_tester
    import adt_pkg::*;
#(
    parameter int NUM_CASES  = 6,
    parameter int STEP_CNT_W = 27
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fault_inj,
    output logic [DATA_W-1:0] shown_a,
    output logic [DATA_W-1:0] shown_b,
    output logic [DATA_W-1:0] shown_sum,
    output logic              mismatch
);

    logic              step;
    logic              cmp_en;
    logic [DATA_W-1:0] tab_a, tab_b, tab_exp;

    adt_step_gen #(.CNT_W(STEP_CNT_W)) u_step (
        .clk  (clk),
        .rst  (rst),
        .step (step)
    );

    adt_sequencer #(.NUM_CASES(NUM_CASES)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .step    (step),
        .tab_a   (tab_a),
        .tab_b   (tab_b),
        .tab_exp (tab_exp),
        .cmp_en  (cmp_en)
    );

    adt_reg_adder u_add (
        .clk      (clk),
        .rst      (rst),
        .op_a_d   (tab_a),
        .op_b_d   (tab_b),
        .flip_lsb (fault_inj),
        .a_q      (shown_a),
        .b_q      (shown_b),
        .s_q      (shown_sum)
    );

    adt_result_check u_chk (
        .clk    (clk),
        .rst    (rst),
        .exp_in (tab_exp),
        .sum_in (shown_sum),
        .cmp_en (cmp_en),
        .err    (mismatch)
    );

endmodule

// File: tb/adt_tester_test.sv
`timescale 1ns/1ps
module adt_tester_test;

    localparam int N   = 6;
    localparam int CW  = 3;
    localparam int PER = 1 << CW;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       fault_inj = 1'b0;
    logic [7:0] shown_a, shown_b, shown_sum;
    logic       mismatch;

    int kcnt;
    int n_chk = 0;
    int n_bad = 0;

    adt_tester #(.NUM_CASES(N), .STEP_CNT_W(CW)) uut (
        .clk       (clk),
        .rst       (rst),
        .fault_inj (fault_inj),
        .shown_a   (shown_a),
        .shown_b   (shown_b),
        .shown_sum (shown_sum),
        .mismatch  (mismatch)
    );

    always #4 clk = ~clk;

    always @(posedge clk or posedge rst) begin
        if (rst) kcnt <= 0;
        else     kcnt <= kcnt + 1;
    end

    function automatic logic [7:0] ta(int i); return 8'(i * 73 + 255); endfunction
    function automatic logic [7:0] tb(int i); return 8'(i * 29 + 3);   endfunction
    function automatic int case_at(int k);
        return (k <= 0) ? 0 : ((k - 1) / PER) % N;
    endfunction
    function automatic logic [7:0] exp_a(int k); return (k == 0) ? 8'h00 : ta(case_at(k - 1)); endfunction
    function automatic logic [7:0] exp_b(int k); return (k == 0) ? 8'h00 : tb(case_at(k - 1)); endfunction
    function automatic logic [7:0] exp_s(int k);
        return (k < 2) ? 8'h00 : 8'(ta(case_at(k - 2)) + tb(case_at(k - 2)));
    endfunction

    task automatic check8(string tag, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at k=%0d actual=%h expected=%h", tag, kcnt, act, exp);
        end
    endtask

    task automatic check1(string tag, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at k=%0d actual=%b expected=%b", tag, kcnt, act, exp);
        end
    endtask

    task automatic apply_reset(logic fault_val);
        @(negedge clk);
        rst = 1'b1;
        fault_inj = fault_val;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic goto(int k);
        while (kcnt < k) @(negedge clk);
    endtask

    task automatic t_reset_state();
        @(negedge clk);
        rst = 1'b1;
        fault_inj = 1'b0;
        @(negedge clk);
        check8("R8 reset operand a", shown_a, 8'h00);
        check8("R8 reset operand b", shown_b, 8'h00);
        check8("R8 reset sum", shown_sum, 8'h00);
        check1("R8 reset flag", mismatch, 1'b0);
    endtask

    task automatic t_sweep();
        apply_reset(1'b0);
        for (int k = 0; k <= PER * N * 2 + 12; k++) begin
            goto(k);
            check8("R1 operand a", shown_a, exp_a(k));
            check8("R1 operand b", shown_b, exp_b(k));
            check8("R2 sum latency", shown_sum, exp_s(k));
            check1("R6 flag low on match", mismatch, 1'b0);
            if (k == PER + 1) check8("R4 first case held PER+1", shown_a, ta(0));
            if (k == PER + 2) check8("R4 second case begins", shown_a, ta(1));
            if (k == 2 * PER + 2) check8("R4 later case spacing", shown_a, ta(2));
            if (k == PER * N + 2) check8("R3 index wraps to 0", shown_b, tb(0));
        end
    endtask

    task automatic t_fault_pulse();
        apply_reset(1'b0);
        goto(4);
        fault_inj = 1'b1;
        goto(5);
        check8("R7 lsb inverted", shown_sum, 8'(ta(0) + tb(0)) ^ 8'h01);
        check1("R6 flag not yet", mismatch, 1'b0);
        fault_inj = 1'b0;
        goto(6);
        check1("R6 flag set on mismatch", mismatch, 1'b1);
        goto(7);
        check1("R6 flag cleared on match", mismatch, 1'b0);
        check8("R7 sum restored", shown_sum, 8'(ta(0) + tb(0)));
    endtask

    task automatic t_fault_over_step();
        apply_reset(1'b0);
        goto(3);
        fault_inj = 1'b1;
        goto(PER);
        check1("R6 flag set before step", mismatch, 1'b1);
        fault_inj = 1'b0;
        goto(PER + 1);
        check1("R5 last compare before step", mismatch, 1'b1);
        goto(PER + 2);
        check1("R5 flag held in fill ops", mismatch, 1'b1);
        goto(PER + 3);
        check1("R5 flag held in fill sum", mismatch, 1'b1);
        goto(PER + 4);
        check1("R5 compare resumes", mismatch, 1'b0);
    endtask

    task automatic t_fault_from_reset();
        apply_reset(1'b1);
        goto(1);
        check1("R5 no compare after reset 1", mismatch, 1'b0);
        goto(2);
        check1("R5 no compare after reset 2", mismatch, 1'b0);
        goto(3);
        check1("R5 first compare flags fault", mismatch, 1'b1);
        fault_inj = 1'b0;
    endtask

    task automatic t_reset_midrun();
        apply_reset(1'b0);
        goto(30);
        #1 rst = 1'b1;
        #1;
        check8("R8 async clear operand a", shown_a, 8'h00);
        check8("R8 async clear sum", shown_sum, 8'h00);
        check1("R8 async clear flag", mismatch, 1'b0);
        @(negedge clk);
        rst = 1'b0;
        goto(1);
        check8("R8 restart at case 0", shown_a, ta(0));
        goto(2);
        check8("R8 restart sum", shown_sum, 8'(ta(0) + tb(0)));
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset_state();
        t_sweep();
        t_fault_pulse();
        t_fault_over_step();
        t_fault_from_reset();
        t_reset_midrun();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule